// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

The encoder turns a stream of digital samples into a one-bit-per-sample code. Each accepted sample is compared with an internal running approximation. The block emits 1 when the sample is strictly above the approximation and 0 otherwise. The approximation then moves toward the sample by an adaptive step.

The step size is held as a thermometer-coded level. When two successive code bits agree, the approximation is lagging the input, so the level grows by one position. When the bits disagree, the approximation has crossed the input, so the level shrinks by one position. The lowest position is always set, so the step is never smaller than one unit. The step magnitude is the number of set positions times a unit step. The approximation clips at zero and at full scale instead of wrapping.

The bit register and the approximation update are pipelined. A code bit appears one cycle after its sample is accepted. The approximation absorbs that bit one cycle later again. The approximation and step level are also driven out, so that a decoder model can be checked beside the encoder.

Top module: `adm_encoder`

## Requirements
- R1: After reset, out_valid is 0, out_bit is 0, approx is 0 and step_code is 1 (only bit 0 set). The stored previous bit is 0.
- R2: A sample accepted with in_valid high at a clock edge gives out_valid high after that edge. It also gives out_bit = 1 if in_sample > approx at that edge and 0 otherwise (equality gives 0). Without in_valid, out_valid is low after the edge and out_bit holds.
- R3: On each accepted sample, step_code grows by one position when the new bit equals the previous bit, and shrinks by one position when it differs. The new bit then becomes the previous bit.
- R4: step_code is a thermometer code with ones filled from bit 0 upward, so N ones means level N. Bit 0 stays 1, so level 1 is the floor. The all-ones code holds when growth is requested again.
- R5: One edge after a bit is produced, approx changes by popcount(step_code) × UNIT, using the step_code value present at that edge. It moves up for bit 1 and down for bit 0. At any other edge approx holds.
- R6: approx saturates at 0 and at 2^W−1 and never wraps.
- R7: An edge without in_valid changes neither step_code nor the stored previous bit.
- R8: A sustained full-scale input from reset drives step_code to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one per sampling cycle |
| in_sample | input | W | Unsigned input sample |
| out_valid | output | 1 | Code bit strobe |
| out_bit | output | 1 | Delta code bit |
| approx | output | W | Current approximation |
| step_code | output | LEVELS | Thermometer step level |

## Verification
A wrong step level shows on step_code at the edge that accepts the sample. It reaches approx one edge later, because the increment there is drawn from the level. A wrong approximation flips the comparison on the next accepted sample, and the error then spreads through out_bit and the step level within a few samples. The bench checks all outputs against an arithmetic model every cycle, so any divergence is reported within one or two cycles of its cause.

// File: rtl/adm_encoder.sv
module adm_encoder #(
  parameter int W      = 12,
  parameter int LEVELS = 8,
  parameter int UNIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      in_sample,
  output logic              out_valid,
  output logic              out_bit,
  output logic [W-1:0]      approx,
  output logic [LEVELS-1:0] step_code
);
  localparam int SW = W + $clog2(LEVELS * UNIT + 1) + 1;
  localparam int CW = $clog2(LEVELS + 1);
  localparam logic [SW-1:0] TOP = SW'((1 << W) - 1);

  logic prev_bit;
  logic upd_due;

  wire cmp_bit = in_sample > approx;
  wire same    = ~(cmp_bit ^ prev_bit);

  wire [LEVELS-1:0] grown  = {step_code[LEVELS-2:0], 1'b1};
  wire [LEVELS-1:0] shrunk = {1'b0, step_code[LEVELS-1:1]} | LEVELS'(1);

  logic [CW-1:0] ones;
  always_comb begin
    ones = '0;
    for (int i = 0; i < LEVELS; i++) ones = ones + CW'(step_code[i]);
  end

  wire [SW-1:0] mag  = SW'(ones) * SW'(UNIT);
  wire [SW-1:0] aext = SW'(approx);
  wire [SW-1:0] up   = (aext + mag > TOP) ? TOP : aext + mag;
  wire [SW-1:0] dn   = (aext < mag) ? '0 : aext - mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      prev_bit  <= 1'b0;
      upd_due   <= 1'b0;
      step_code <= LEVELS'(1);
    end else begin
      out_valid <= in_valid;
      upd_due   <= in_valid;
      if (in_valid) begin
        out_bit   <= cmp_bit;
        prev_bit  <= cmp_bit;
        step_code <= same ? grown : shrunk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       approx <= '0;
    else if (upd_due) approx <= out_bit ? up[W-1:0] : dn[W-1:0];
  end

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_bit));
  a_r3_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && same) |=> $countones(step_code) ==
      (($countones($past(step_code)) == LEVELS) ? LEVELS : $countones($past(step_code)) + 1));
  a_r3_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !same) |=> $countones(step_code) ==
      (($countones($past(step_code)) == 1) ? 1 : $countones($past(step_code)) - 1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_due |=> $stable(approx));
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_due && out_bit) |=> approx >= $past(approx));
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_due && !out_bit) |=> approx <= $past(approx));
  a_r7_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(step_code) && $stable(prev_bit));
endmodule

// File: tb/adm_encoder_test.sv
module adm_encoder_test;
  localparam int W = 8, L = 8, U = 3;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_sample = '0;
  logic out_valid, out_bit;
  logic [W-1:0] approx;
  logic [L-1:0] step_code;

  int errors = 0, checks = 0, cycles = 0;
  int m_a = 0;
  logic [L-1:0] m_s = 1;
  logic m_p = 0, m_u = 0, m_o = 0, m_v = 0;
  bit saw_full = 0, saw_top = 0;

  always #4 clk = ~clk;

  adm_encoder #(.W(W), .LEVELS(L), .UNIT(U)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_bit(out_bit), .approx(approx), .step_code(step_code));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic check_all();
    chk("R2 out_valid", int'(out_valid), int'(m_v));
    if (m_v) chk("R2 out_bit", int'(out_bit), int'(m_o));
    chk("R5/R6 approx", int'(approx), m_a);
    chk("R3/R4 step_code", int'(step_code), int'(m_s));
    if (step_code == '1) saw_full = 1;
    if (approx == TOPV) saw_top = 1;
  endtask

  task automatic model_next(input logic v, input logic [W-1:0] s);
    logic nb;
    int mag;
    nb = int'(s) > m_a;
    if (m_u) begin
      mag = $countones(m_s) * U;
      if (m_o) m_a = (m_a + mag > TOPV) ? TOPV : m_a + mag;
      else     m_a = (m_a < mag) ? 0 : m_a - mag;
    end
    m_v = v;
    m_u = v;
    if (v) begin
      if (nb == m_p) m_s = {m_s[L-2:0], 1'b1};
      else           m_s = {1'b0, m_s[L-1:1]} | L'(1);
      m_o = nb;
      m_p = nb;
    end
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] s);
    @(negedge clk);
    check_all();
    in_valid = v;
    in_sample = s;
    model_next(v, s);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_bit", int'(out_bit), 0);
    chk("R1 approx", int'(approx), 0);
    chk("R1 step_code", int'(step_code), 1);

    // R8 steep startup: full-scale input from reset
    for (int n = 0; n < 40; n++) cyc(1, 8'(TOPV));
    chk("R8 step reached all ones", int'(saw_full), 1);
    chk("R6 approx clipped at full scale", int'(saw_top), 1);

    // R7 idle gap: nothing moves
    for (int n = 0; n < 5; n++) cyc(0, 8'h00);

    // sine table
    for (int n = 0; n < 256; n++)
      cyc(1, 8'($rtoi(128.0 + 100.0 * $sin(6.283185307 * n / 64.0))));

    // slow ramp up and down
    for (int n = 0; n < 256; n++) cyc(1, 8'(n));
    for (int n = 255; n >= 0; n--) cyc(1, 8'(n));

    // pseudo-random input with idle gaps (R7)
    lfsr = 8'h5a;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc((n % 3) != 2, lfsr);
    end

    // R6 floor: zero input drives approx to 0 and holds there
    for (int n = 0; n < 120; n++) cyc(1, 8'h00);
    @(negedge clk);
    check_all();
    chk("R6 approx held at zero", int'(approx), 0);
    chk("R4 step floor stays at level one or grows", int'(step_code[0]), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule